// File: doc/BRIEF.md
# Flash Erase Command Sequencer and Status Register

This block sits between a flash memory's write port and its storage array. Every write carries an 8-bit command code on the low data bits and an 18-bit double-word address. The block decodes these writes, runs the two-write erase sequences for the 32 main blocks and for the overlay block that shares block 0's address range, and reports progress in an 8-bit status byte. It also tells the read path whether array reads should return the status byte instead of array data.

Toward a behavioural array model it drives a one-cycle erase start pulse, a block index, an overlay flag, a hold level while an erase is suspended and an abort pulse when the supply fails. It receives a done pulse and a fail flag back. Two level inputs report whether the program/erase supply is in range and whether the overlay block is enabled.

Top module: `flash_cmd_if`

## Requirements
- R1: A write of 20h at address 0 followed by a write of D0h, with the supply valid, pulses `erase_start` for one cycle in the cycle after the confirm write. `erase_blk` then holds address bits 17..13 of the confirm write and `erase_ovl` is 0. Status bit 7 reads 0 from that cycle until the erase ends.
- R2: If the write after a main setup is not D0h, status bits 5 and 4 are set, no erase starts and the sequencer returns to idle.
- R3: A write of 02h at address 0 followed by 0Dh at an address whose bits 17..13 are 0 starts an overlay erase, with `erase_ovl`=1 and `erase_blk`=0. Any other second write sets only status bit 5 and starts nothing.
- R4: An `erase_done` pulse during a running erase sets bit 7 to 1 in the next cycle. If `erase_fail` is high with it, bit 5 is also set.
- R5: While a main erase runs, only suspend (B0h) changes anything. While an overlay erase runs, no write has any effect.
- R6: B0h during a main erase sets bits 7, 6 and 5 and raises `erase_hold`. `erase_done` is ignored while suspended. D0h resumes: bit 6 and the suspend-driven bit 5 clear, bit 7 returns to 0 and `erase_hold` falls.
- R7: A confirm write with `supply_ok` low sets bit 3 and starts nothing. `supply_ok` low during a running erase sets bit 3, pulses `erase_abort` for one cycle and returns to idle.
- R8: Bits 5, 4 and 3, once set, stay set until a clear-status write (50h) in idle or in suspend.
- R9: Bit 1 follows `overlay_en`. Bit 0 is `overlay_en` AND `supply_ok`. Both are combinational. Bit 2 is always 0.
- R10: `rd_status` goes to 1 after 70h or after an accepted setup write, and to 0 after FFh in idle or in suspend. It is 1 whenever bit 7 is 0.
- R11: In idle, any unknown code is ignored, and so is a setup code at a non-zero address. The block stays idle.
- R12: A synchronous low `rst_n` returns the block to idle, clears bits 5..3 and `rd_status`, and abandons any erase in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | 18 | Double-word address of the write |
| wr_data | input | 8 | Command code |
| supply_ok | input | 1 | Program/erase supply in range |
| overlay_en | input | 1 | Overlay block enabled |
| erase_done | input | 1 | Array finished the erase (pulse) |
| erase_fail | input | 1 | Array erase failed, valid with done |
| erase_start | output | 1 | Start an erase (one-cycle pulse) |
| erase_blk | output | 5 | Block index of the erase |
| erase_ovl | output | 1 | Erase targets the overlay block |
| erase_hold | output | 1 | Erase suspended |
| erase_abort | output | 1 | Erase abandoned on supply loss (pulse) |
| rd_status | output | 1 | Array reads return the status byte |
| status | output | 8 | Status byte |

## Verification
A sequencer stuck in the wrong state shows at the ports at once. Bit 7, bit 6 and `erase_hold` come straight from the state, so they diverge in the cycle after the write or done pulse that was mishandled. A lost or spurious sticky error bit shows in the same cycle after the offending write and then persists until a clear. This makes a per-cycle comparison against a behavioural model pin the fault to a single clock.

// File: rtl/fci_pkg.sv
// Shared types for the flash command interface.
// Assumes: command codes arrive on an 8-bit field.
package fci_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_MSET, S_OSET, S_MRUN, S_ORUN, S_MSUS
    } fci_state_e;

    typedef enum logic [3:0] {
        C_NONE, C_RDARR, C_RDSTAT, C_CLR, C_MSETUP, C_OSETUP,
        C_D0, C_OCONF, C_SUSP
    } fci_cmd_e;
endpackage

// File: rtl/fci_decode.sv
// Classifies a command byte into a command kind.
// Assumes: purely combinational; unknown codes map to C_NONE.
module fci_decode
    import fci_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] code,
    output fci_cmd_e          cmd
);
    // Map each supported code byte to its command kind.
    always_comb begin
        case (code)
            8'hFF:   cmd = C_RDARR;
            8'h70:   cmd = C_RDSTAT;
            8'h50:   cmd = C_CLR;
            8'h20:   cmd = C_MSETUP;
            8'h02:   cmd = C_OSETUP;
            8'hD0:   cmd = C_D0;
            8'h0D:   cmd = C_OCONF;
            8'hB0:   cmd = C_SUSP;
            default: cmd = C_NONE;
        endcase
    end
endmodule

// File: rtl/fci_seq.sv
// Erase command sequencer: setup/confirm checking, busy, suspend and abort.
// Assumes: one write per cycle; erase_done is a single-cycle pulse.
// Priority while running: supply loss, then done, then a write.
module fci_seq
    import fci_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BLK_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  fci_cmd_e          cmd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              supply_ok,
    input  logic              erase_done,
    input  logic              erase_fail,
    output fci_state_e        state,
    output logic              rd_status,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              erase_ovl,
    output logic              erase_abort,
    output logic              ev_set54,
    output logic              ev_set5,
    output logic              ev_set3,
    output logic              ev_clr
);
    fci_state_e       state_n;
    logic             rd_n, start_n, ovl_n, abort_n;
    logic [BLK_W-1:0] blk_n;
    logic             addr_zero, in_ovl;
    logic [BLK_W-1:0] tgt_blk;

    assign addr_zero = (wr_addr == '0);
    assign tgt_blk   = wr_addr[ADDR_W-1 -: BLK_W];
    assign in_ovl    = (tgt_blk == '0);

    // Next-state, output and status-event decision for the current write.
    always_comb begin
        state_n  = state;
        rd_n     = rd_status;
        start_n  = 1'b0;
        blk_n    = erase_blk;
        ovl_n    = erase_ovl;
        abort_n  = 1'b0;
        ev_set54 = 1'b0;
        ev_set5  = 1'b0;
        ev_set3  = 1'b0;
        ev_clr   = 1'b0;
        case (state)
            S_IDLE: if (wr_en) begin
                case (cmd)
                    C_RDARR:  rd_n = 1'b0;
                    C_RDSTAT: rd_n = 1'b1;
                    C_CLR:    ev_clr = 1'b1;
                    C_MSETUP: if (addr_zero) begin state_n = S_MSET; rd_n = 1'b1; end
                    C_OSETUP: if (addr_zero) begin state_n = S_OSET; rd_n = 1'b1; end
                    default:  ;
                endcase
            end
            S_MSET: if (wr_en) begin
                state_n = S_IDLE;
                if (cmd != C_D0)     ev_set54 = 1'b1;
                else if (!supply_ok) ev_set3  = 1'b1;
                else begin
                    state_n = S_MRUN;
                    start_n = 1'b1;
                    blk_n   = tgt_blk;
                    ovl_n   = 1'b0;
                end
            end
            S_OSET: if (wr_en) begin
                state_n = S_IDLE;
                if (cmd != C_OCONF || !in_ovl) ev_set5 = 1'b1;
                else if (!supply_ok)           ev_set3 = 1'b1;
                else begin
                    state_n = S_ORUN;
                    start_n = 1'b1;
                    blk_n   = '0;
                    ovl_n   = 1'b1;
                end
            end
            S_MRUN, S_ORUN: begin
                if (!supply_ok) begin
                    ev_set3 = 1'b1;
                    abort_n = 1'b1;
                    state_n = S_IDLE;
                end else if (erase_done) begin
                    ev_set5 = erase_fail;
                    state_n = S_IDLE;
                end else if (wr_en && cmd == C_SUSP && state == S_MRUN) begin
                    state_n = S_MSUS;
                end
            end
            S_MSUS: if (wr_en) begin
                case (cmd)
                    C_D0:     begin state_n = S_MRUN; rd_n = 1'b1; end
                    C_RDARR:  rd_n = 1'b0;
                    C_RDSTAT: rd_n = 1'b1;
                    C_CLR:    ev_clr = 1'b1;
                    default:  ;
                endcase
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Register the sequencer state and array-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            rd_status   <= 1'b0;
            erase_start <= 1'b0;
            erase_blk   <= '0;
            erase_ovl   <= 1'b0;
            erase_abort <= 1'b0;
        end else begin
            state       <= state_n;
            rd_status   <= rd_n;
            erase_start <= start_n;
            erase_blk   <= blk_n;
            erase_ovl   <= ovl_n;
            erase_abort <= abort_n;
        end
    end

    // R1: the start request lasts exactly one cycle.
    a_r1_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);
    // R7: the abort request lasts one cycle and leaves the sequencer idle.
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        erase_abort |-> (state == S_IDLE));
endmodule

// File: rtl/fci_status.sv
// Status byte: sticky error flags plus live ready/suspend/overlay bits.
// Assumes: set and clear events never arrive in the same cycle.
module fci_status #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_set54,
    input  logic            ev_set5,
    input  logic            ev_set3,
    input  logic            ev_clr,
    input  logic            busy,
    input  logic            susp,
    input  logic            overlay_en,
    input  logic            supply_ok,
    output logic [SR_W-1:0] status
);
    logic err5, err4, err3;

    // Hold the sticky error flags until a clear event.
    always_ff @(posedge clk) begin
        if (!rst_n || ev_clr) begin
            err5 <= 1'b0;
            err4 <= 1'b0;
            err3 <= 1'b0;
        end else begin
            err5 <= err5 | ev_set54 | ev_set5;
            err4 <= err4 | ev_set54;
            err3 <= err3 | ev_set3;
        end
    end

    // Assemble the status byte from flags and live conditions.
    always_comb begin
        status    = '0;
        status[7] = !busy;
        status[6] = susp;
        status[5] = err5 | susp;
        status[4] = err4;
        status[3] = err3;
        status[1] = overlay_en;
        status[0] = overlay_en & supply_ok;
    end

    // R8: a set supply flag persists unless cleared.
    a_r8_err3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err3 && !ev_clr) |=> err3);
    // R8: the erase-error flag persists unless cleared.
    a_r8_err5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err5 && !ev_clr) |=> err5);
endmodule

// File: rtl/flash_cmd_if.sv
// Flash command interface top: decoder, erase sequencer and status byte.
// Assumes: a behavioural array answers erase_start with one erase_done pulse.
module flash_cmd_if
    import fci_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int BLK_W  = 5,
    parameter int SR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              supply_ok,
    input  logic              overlay_en,
    input  logic              erase_done,
    input  logic              erase_fail,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              erase_ovl,
    output logic              erase_hold,
    output logic              erase_abort,
    output logic              rd_status,
    output logic [SR_W-1:0]   status
);
    fci_cmd_e   cmd;
    fci_state_e state;
    logic       ev_set54, ev_set5, ev_set3, ev_clr, busy, susp;

    fci_decode #(.DATA_W(DATA_W)) u_dec (.code(wr_data), .cmd(cmd));

    fci_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(cmd), .wr_addr(wr_addr),
        .supply_ok(supply_ok), .erase_done(erase_done), .erase_fail(erase_fail),
        .state(state), .rd_status(rd_status), .erase_start(erase_start),
        .erase_blk(erase_blk), .erase_ovl(erase_ovl), .erase_abort(erase_abort),
        .ev_set54(ev_set54), .ev_set5(ev_set5), .ev_set3(ev_set3), .ev_clr(ev_clr)
    );

    assign busy       = (state == S_MRUN) || (state == S_ORUN);
    assign susp       = (state == S_MSUS);
    assign erase_hold = susp;

    fci_status #(.SR_W(SR_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .ev_set54(ev_set54), .ev_set5(ev_set5),
        .ev_set3(ev_set3), .ev_clr(ev_clr), .busy(busy), .susp(susp),
        .overlay_en(overlay_en), .supply_ok(supply_ok), .status(status)
    );

    // R1: a start is only issued while the status byte reports busy.
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> !status[7]);
    // R7: an abort is always accompanied by the supply flag.
    a_r7_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        erase_abort |-> status[3]);
    // R10: whenever busy, reads return the status byte.
    a_r10_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7] |-> rd_status);
    // R6: hold is raised only together with the suspend flag.
    a_r6_hold_susp: assert property (@(posedge clk) disable iff (!rst_n)
        erase_hold |-> (status[6] && status[7]));
endmodule

// File: tb/flash_cmd_if_tb.sv
// Bench: behavioural reference model compared with the design every cycle.
module flash_cmd_if_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        supply_ok = 1'b1;
    logic        overlay_en = 1'b0;
    logic        erase_done = 1'b0;
    logic        erase_fail = 1'b0;
    logic        erase_start, erase_ovl, erase_hold, erase_abort, rd_status;
    logic [4:0]  erase_blk;
    logic [7:0]  status;

    int tests = 0;
    int fails = 0;
    string cur_req = "R12";
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .supply_ok(supply_ok), .overlay_en(overlay_en), .erase_done(erase_done),
        .erase_fail(erase_fail), .erase_start(erase_start), .erase_blk(erase_blk),
        .erase_ovl(erase_ovl), .erase_hold(erase_hold), .erase_abort(erase_abort),
        .rd_status(rd_status), .status(status)
    );

    // Reference model: 0 idle, 1 main setup, 2 overlay setup, 3 main run, 4 overlay run, 5 suspended
    int m_st = 0;
    bit m_e5, m_e4, m_e3, m_rd, m_start, m_ovl, m_abort;
    int m_blk = 0;

    always @(posedge clk) begin
        m_start <= 0;
        m_abort <= 0;
        if (!rst_n) begin
            m_st <= 0; m_e5 <= 0; m_e4 <= 0; m_e3 <= 0; m_rd <= 0;
            m_blk <= 0; m_ovl <= 0;
        end else if (m_st == 0) begin
            if (wr_en) begin
                if (wr_data == 8'hFF) m_rd <= 0;
                if (wr_data == 8'h70) m_rd <= 1;
                if (wr_data == 8'h50) begin m_e5 <= 0; m_e4 <= 0; m_e3 <= 0; end
                if (wr_data == 8'h20 && wr_addr == 0) begin m_st <= 1; m_rd <= 1; end
                if (wr_data == 8'h02 && wr_addr == 0) begin m_st <= 2; m_rd <= 1; end
            end
        end else if (m_st == 1) begin
            if (wr_en) begin
                m_st <= 0;
                if (wr_data != 8'hD0) begin m_e5 <= 1; m_e4 <= 1; end
                else if (!supply_ok) m_e3 <= 1;
                else begin m_st <= 3; m_start <= 1; m_blk <= int'(wr_addr) / 8192; m_ovl <= 0; end
            end
        end else if (m_st == 2) begin
            if (wr_en) begin
                m_st <= 0;
                if (wr_data != 8'h0D || wr_addr >= 18'h02000) m_e5 <= 1;
                else if (!supply_ok) m_e3 <= 1;
                else begin m_st <= 4; m_start <= 1; m_blk <= 0; m_ovl <= 1; end
            end
        end else if (m_st == 3 || m_st == 4) begin
            if (!supply_ok) begin m_e3 <= 1; m_abort <= 1; m_st <= 0; end
            else if (erase_done) begin if (erase_fail) m_e5 <= 1; m_st <= 0; end
            else if (wr_en && wr_data == 8'hB0 && m_st == 3) m_st <= 5;
        end else begin
            if (wr_en) begin
                if (wr_data == 8'hD0) begin m_st <= 3; m_rd <= 1; end
                if (wr_data == 8'hFF) m_rd <= 0;
                if (wr_data == 8'h70) m_rd <= 1;
                if (wr_data == 8'h50) begin m_e5 <= 0; m_e4 <= 0; m_e3 <= 0; end
            end
        end
    end

    function automatic logic [7:0] exp_status();
        logic [7:0] s = '0;
        s[7] = !(m_st == 3 || m_st == 4);
        s[6] = (m_st == 5);
        s[5] = m_e5 || (m_st == 5);
        s[4] = m_e4;
        s[3] = m_e3;
        s[1] = overlay_en;
        s[0] = overlay_en && supply_ok;
        return s;
    endfunction

    // Compare every output with the model a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!finished) begin
            logic [15:0] act, exp;
            act = {status, rd_status, erase_start, erase_blk[4:0], erase_ovl};
            exp = {exp_status(), m_rd, m_start, 5'(m_blk), m_ovl};
            tests++;
            if (act !== exp || erase_hold !== (m_st == 5) || erase_abort !== m_abort) begin
                fails++;
                $display("FAIL %s t=%0t actual sr=%h rd=%b st=%b blk=%0d ovl=%b hold=%b ab=%b expected sr=%h rd=%b st=%b blk=%0d ovl=%b hold=%b ab=%b",
                    cur_req, $time, status, rd_status, erase_start, erase_blk, erase_ovl, erase_hold, erase_abort,
                    exp_status(), m_rd, m_start, m_blk, m_ovl, (m_st == 5), m_abort);
            end
        end
    end

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic done(input bit f);
        @(negedge clk); erase_done = 1; erase_fail = f;
        @(negedge clk); erase_done = 0; erase_fail = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R12"; idle(3); @(negedge clk); rst_n = 1; idle(2);
        cur_req = "R9";  overlay_en = 1; idle(2); supply_ok = 0; idle(2); supply_ok = 1; overlay_en = 0; idle(2);
        cur_req = "R11"; wr(18'h0, 8'h33); wr(18'h02000, 8'h20); wr(18'h00004, 8'h02); idle(2);
        cur_req = "R10"; wr(0, 8'h70); wr(0, 8'hFF); idle(1);
        cur_req = "R1";  wr(0, 8'h20); wr(18'h2A123, 8'hD0); idle(3);
        cur_req = "R5";  wr(0, 8'hFF); wr(0, 8'h50); wr(0, 8'h02); wr(0, 8'h70); idle(1);
        cur_req = "R4";  done(0); idle(2);
        cur_req = "R4";  wr(0, 8'h20); wr(18'h3FFFF, 8'hD0); idle(2); done(1); idle(2);
        cur_req = "R8";  wr(0, 8'h70); wr(0, 8'hFF); wr(0, 8'h33); idle(2); wr(0, 8'h50); idle(1);
        cur_req = "R2";  wr(0, 8'h20); wr(18'h04000, 8'h40); idle(2); wr(0, 8'h50);
        cur_req = "R3";  overlay_en = 1; wr(0, 8'h02); wr(18'h01000, 8'h0D); idle(1);
        cur_req = "R5";  wr(0, 8'hB0); wr(0, 8'hFF); idle(1); done(0); idle(1);
        cur_req = "R3";  wr(0, 8'h02); wr(18'h02000, 8'h0D); idle(1); wr(0, 8'h50);
        wr(0, 8'h02); wr(18'h0, 8'hD0); idle(1); wr(0, 8'h50); overlay_en = 0;
        cur_req = "R6";  wr(0, 8'h20); wr(18'h10000, 8'hD0); idle(1); wr(0, 8'hB0); idle(2);
        done(0); wr(0, 8'hFF); wr(0, 8'h70); wr(0, 8'h50); wr(0, 8'hD0); idle(2); done(0); idle(1);
        cur_req = "R7";  supply_ok = 0; wr(0, 8'h20); wr(18'h06000, 8'hD0); idle(1); supply_ok = 1;
        wr(0, 8'h50); wr(0, 8'h20); wr(18'h08000, 8'hD0); idle(2); supply_ok = 0; idle(2); supply_ok = 1; idle(1);
        cur_req = "R8";  wr(0, 8'h20); wr(0, 8'h11); idle(1); wr(0, 8'h50); idle(1);
        cur_req = "R12"; wr(0, 8'h20); wr(18'h0C000, 8'hD0); idle(1); rst_n = 0; idle(2); rst_n = 1; idle(3);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule